// File: doc/BRIEF.md
# Strobe-Driven Multi-Queue Read Port

This block holds a small set of independent queues. Local logic loads them through a synchronous valid/ready push port. An external host drains them through active-low asynchronous strobes: a select, an output enable and a read strobe. A two-bit queue address chooses which queue the host sees. An internal clock samples every host-side input through two-flop synchronizers. The block then decides when the data bus is driven, which word it carries, and when a read has consumed that word.

Output enable on its own shows the head word of the addressed queue without consuming it. A read is counted only while the select and the read strobe are both low. The head is consumed once, on the release of that qualified strobe. Back-to-back strobe pulses therefore walk through consecutive words. Output enable and read strobe may be wired together. Per-queue empty and full flags, the flags of the addressed queue and a sticky underflow indication report the state of the queues.

Push back-pressure: a word offered with `wr_valid` high is taken on a clock edge only when `wr_ready` is high. `wr_ready` is low exactly while the queue named by `wr_sel` is full. The offering side holds the word until it is taken.

Top module: `slave_fifo_rdport`

## Requirements
- R1: `bus_oe` equals the inverse of `oe_n` as sampled three clock edges earlier (two synchronizer stages plus the output register). While `bus_oe` is 0, `bus_data` is all zeros.
- R2: With output enable low and no read pulse, `bus_data` shows the head word of the addressed queue and keeps showing it; the head is not consumed.
- R3: A read pulse on `rd_n` while `cs_n` is high consumes nothing.
- R4: A pulse on `rd_n` while `cs_n` is low consumes exactly one word. The consume happens on the clock edge at which the synchronized strobe is seen released, three edges after the raw `rd_n` rises.
- R5: Successive qualified pulses with output enable held low present consecutive words N, N+1, N+2 of the addressed queue.
- R6: With `oe_n` and `rd_n` driven as one signal, each pulse shows the head word and then consumes it.
- R7: A qualified pulse on an empty queue leaves that queue unchanged and sets `underflow`, which stays set until reset.
- R8: `empty_vec[i]` and `full_vec[i]` report queue i empty (0 words) or full (DEPTH words). `sel_empty`/`sel_full` report the flags of the queue named by `fifo_addr` as sampled two edges earlier.
- R9: A word with `wr_valid` high and `wr_ready` high is appended to queue `wr_sel`. `wr_ready` is 0 exactly while that queue is full, and an offer to a full queue is dropped.
- R10: Reset empties every queue, clears `underflow` and releases the bus (`bus_oe` 0, `bus_data` 0).
- R11: Changing `fifo_addr` with no read pulse switches the bus to the head word of the newly addressed queue without consuming in either queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_valid | input | 1 | push offer |
| wr_ready | output | 1 | push accepted this edge when high |
| wr_sel | input | 2 | queue to push into |
| wr_data | input | 16 | word to push |
| cs_n | input | 1 | host select, active low, asynchronous |
| oe_n | input | 1 | host output enable, active low, asynchronous |
| rd_n | input | 1 | host read strobe, active low, asynchronous |
| fifo_addr | input | 2 | host queue address, asynchronous |
| bus_data | output | 16 | data toward the host pad |
| bus_oe | output | 1 | pad drive enable |
| sel_empty | output | 1 | addressed queue empty |
| sel_full | output | 1 | addressed queue full |
| empty_vec | output | 4 | per-queue empty flags |
| full_vec | output | 4 | per-queue full flags |
| underflow | output | 1 | sticky read-while-empty indication |

## Verification
The assertions assume that host strobes are held for at least three clocks in each state. This ensures the synchronized read strobe never pulses for a single cycle. They also assume that `fifo_addr` stays fixed from before a read strobe asserts until several clocks after it releases. The stimulus drives every host input on the falling clock edge and holds each strobe level for three or more cycles. It changes the address only while no read is in flight. The push port offers words one clock at a time and removes an offer after one edge.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // synchronized host controls, active high after inversion
  typedef struct packed {
    logic sel;
    logic oe;
    logic rd;
  } host_ctl_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage [sfifo_pkg::SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(sfifo_pkg::SYNC_STAGES); i++) stage[i] <= IDLE;
    end else begin
      stage[0] <= async_in;
      for (int i = 1; i < int'(sfifo_pkg::SYNC_STAGES); i++) stage[i] <= stage[i-1];
    end
  end

  assign sync_out = stage[sfifo_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/read_qualifier.sv
module read_qualifier #(
  parameter int unsigned SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sfifo_pkg::host_ctl_t ctl,
  input  logic [SEL_W-1:0]     addr,
  output logic                 pop_req,
  output logic [SEL_W-1:0]     pop_sel
);
  logic rd_live;
  logic rd_prev;

  assign rd_live = ctl.sel & ctl.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev <= 1'b0;
    else        rd_prev <= rd_live;
  end

  // one consume per qualified pulse, on its release
  assign pop_req = rd_prev & ~rd_live;
  assign pop_sel = addr;
endmodule

// File: rtl/fifo_bank.sv
module fifo_bank #(
  parameter int unsigned NUM   = 4,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 16,
  localparam int unsigned SEL_W = $clog2(NUM),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [DW-1:0]         wr_data,
  input  logic                  pop_req,
  input  logic [SEL_W-1:0]      pop_sel,
  output logic [NUM-1:0][DW-1:0] heads,
  output logic [NUM-1:0]        empty_vec,
  output logic [NUM-1:0]        full_vec,
  output logic                  underflow
);
  for (genvar g = 0; g < int'(NUM); g++) begin : g_q
    logic [DW-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] rptr;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W:0]   cnt;
    logic push_g;
    logic pop_g;

    assign empty_vec[g] = (cnt == '0);
    assign full_vec[g]  = (cnt == (PTR_W+1)'(DEPTH));
    assign push_g = wr_en && (wr_sel == SEL_W'(g)) && !full_vec[g];
    assign pop_g  = pop_req && (pop_sel == SEL_W'(g)) && !empty_vec[g];
    assign heads[g] = mem[rptr];

    always_ff @(posedge clk) begin
      if (push_g) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rptr <= '0;
        wptr <= '0;
        cnt  <= '0;
      end else begin
        if (push_g) wptr <= wptr + 1'b1;
        if (pop_g)  rptr <= rptr + 1'b1;
        case ({push_g, pop_g})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            underflow <= 1'b0;
    else if (pop_req && empty_vec[pop_sel]) underflow <= 1'b1;
  end
endmodule

// File: rtl/slave_fifo_rdport.sv
module slave_fifo_rdport #(
  parameter int unsigned NUM   = 4,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 16,
  localparam int unsigned SEL_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic             rd_n,
  input  logic [SEL_W-1:0] fifo_addr,
  output logic [DW-1:0]    bus_data,
  output logic             bus_oe,
  output logic             sel_empty,
  output logic             sel_full,
  output logic [NUM-1:0]   empty_vec,
  output logic [NUM-1:0]   full_vec,
  output logic             underflow
);
  localparam int unsigned SW = 3 + SEL_W;

  logic [SW-1:0]          sync_q;
  sfifo_pkg::host_ctl_t   ctl;
  logic [SEL_W-1:0]       addr_s;
  logic                   pop_req;
  logic [SEL_W-1:0]       pop_sel;
  logic [NUM-1:0][DW-1:0] heads;

  strobe_sync #(.WIDTH(SW), .IDLE('0)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({~cs_n, ~oe_n, ~rd_n, fifo_addr}),
    .sync_out (sync_q)
  );

  assign ctl    = sfifo_pkg::host_ctl_t'(sync_q[SW-1 -: 3]);
  assign addr_s = sync_q[SEL_W-1:0];

  read_qualifier #(.SEL_W(SEL_W)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .addr    (addr_s),
    .pop_req (pop_req),
    .pop_sel (pop_sel)
  );

  fifo_bank #(.NUM(NUM), .DEPTH(DEPTH), .DW(DW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_valid),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .pop_req   (pop_req),
    .pop_sel   (pop_sel),
    .heads     (heads),
    .empty_vec (empty_vec),
    .full_vec  (full_vec),
    .underflow (underflow)
  );

  assign wr_ready  = !full_vec[wr_sel];
  assign sel_empty = empty_vec[addr_s];
  assign sel_full  = full_vec[addr_s];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe   <= 1'b0;
      bus_data <= '0;
    end else begin
      bus_oe   <= ctl.oe;
      bus_data <= ctl.oe ? heads[addr_s] : '0;
    end
  end
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int unsigned NUM = 4,
  parameter int unsigned DW  = 16,
  localparam int unsigned SEL_W = $clog2(NUM)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [SEL_W-1:0] wr_sel,
  input logic [DW-1:0]    bus_data,
  input logic             bus_oe,
  input logic [NUM-1:0]   empty_vec,
  input logic [NUM-1:0]   full_vec,
  input logic             underflow,
  input logic             pop_req,
  input logic [SEL_W-1:0] pop_sel
);
  a_r1_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_data == '0);

  a_r4_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |=> !pop_req);

  a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  a_r7_empty_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty_vec[pop_sel]) |=> underflow);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_vec & full_vec) == '0);

  a_r9_full_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full_vec[wr_sel]) |-> !wr_ready);
endmodule

bind slave_fifo_rdport sfifo_checker #(.NUM(NUM), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_sel    (wr_sel),
  .bus_data  (bus_data),
  .bus_oe    (bus_oe),
  .empty_vec (empty_vec),
  .full_vec  (full_vec),
  .underflow (underflow),
  .pop_req   (pop_req),
  .pop_sel   (pop_sel)
);

// File: tb/tb_slave_fifo_rdport.sv
module tb_slave_fifo_rdport;
  localparam int NUM = 4;
  localparam int DEPTH = 512;
  localparam int DW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_valid = 0;
  logic wr_ready;
  logic [1:0] wr_sel = 0;
  logic [DW-1:0] wr_data = 0;
  logic cs_n = 1, oe_n = 1, rd_n = 1;
  logic [1:0] fifo_addr = 0;
  logic [DW-1:0] bus_data;
  logic bus_oe, sel_empty, sel_full, underflow;
  logic [NUM-1:0] empty_vec, full_vec;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  slave_fifo_rdport #(.NUM(NUM), .DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .cs_n(cs_n), .oe_n(oe_n), .rd_n(rd_n),
    .fifo_addr(fifo_addr), .bus_data(bus_data), .bus_oe(bus_oe),
    .sel_empty(sel_empty), .sel_full(sel_full), .empty_vec(empty_vec),
    .full_vec(full_vec), .underflow(underflow)
  );

  // reference model
  int unsigned q [NUM][$];
  logic h_cs [4], h_oe [4], h_rd [4];
  logic [1:0] h_ad [4];
  logic m_oe, m_data_known, m_uf;
  logic [DW-1:0] m_data;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) q[i].delete();
      for (int i = 0; i < 4; i++) begin
        h_cs[i] = 1; h_oe[i] = 1; h_rd[i] = 1; h_ad[i] = 0;
      end
      m_oe = 0; m_data = 0; m_data_known = 1; m_uf = 0;
    end else begin
      logic act3, act2, do_pop, do_push;
      int pf;
      for (int i = 3; i > 0; i--) begin
        h_cs[i] = h_cs[i-1]; h_oe[i] = h_oe[i-1]; h_rd[i] = h_rd[i-1]; h_ad[i] = h_ad[i-1];
      end
      h_cs[0] = cs_n; h_oe[0] = oe_n; h_rd[0] = rd_n; h_ad[0] = fifo_addr;
      // R1/R2: bus register follows controls seen two edges ago
      m_oe = !h_oe[2];
      if (!m_oe) begin m_data = 0; m_data_known = 1; end
      else if (q[h_ad[2]].size() > 0) begin m_data = DW'(q[h_ad[2]][0]); m_data_known = 1; end
      else m_data_known = 0;
      // R4: consume on release of qualified strobe
      act3 = !h_cs[3] && !h_rd[3];
      act2 = !h_cs[2] && !h_rd[2];
      pf = int'(h_ad[2]);
      do_pop = act3 && !act2 && q[pf].size() > 0;
      if (act3 && !act2 && q[pf].size() == 0) m_uf = 1;
      do_push = wr_valid && q[wr_sel].size() < DEPTH;
      if (do_pop) void'(q[pf].pop_front());
      if (do_push) q[wr_sel].push_back(int'(wr_data));
    end
    #2;
    if (rst_n) begin
      chk(bus_oe == m_oe, "R1 bus_oe", bus_oe, m_oe);
      if (m_data_known) chk(bus_data == m_data, "R2 bus_data", bus_data, m_data);
      chk(underflow == m_uf, "R7 underflow", underflow, m_uf);
      for (int i = 0; i < NUM; i++) begin
        chk(empty_vec[i] == (q[i].size() == 0), "R8 empty_vec", empty_vec[i], q[i].size() == 0);
        chk(full_vec[i] == (q[i].size() == DEPTH), "R8 full_vec", full_vec[i], q[i].size() == DEPTH);
      end
      chk(sel_empty == (q[h_ad[1]].size() == 0), "R8 sel_empty", sel_empty, q[h_ad[1]].size() == 0);
      chk(sel_full == (q[h_ad[1]].size() == DEPTH), "R8 sel_full", sel_full, q[h_ad[1]].size() == DEPTH);
      chk(wr_ready == (q[wr_sel].size() < DEPTH), "R9 wr_ready", wr_ready, q[wr_sel].size() < DEPTH);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd_pulse(input logic tie_oe);
    @(negedge clk);
    rd_n = 0; if (tie_oe) oe_n = 0;
    wait_cyc(4);
    rd_n = 1; if (tie_oe) oe_n = 1;
    wait_cyc(5);
  endtask

  task automatic probe(input string tag, input logic [DW-1:0] exp);
    @(posedge clk); #3;
    chk(bus_oe && bus_data == exp, tag, bus_data, exp);
    @(negedge clk);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    @(posedge clk); #3;
    // R10: reset state
    chk(bus_oe == 0 && bus_data == 0, "R10 bus released", bus_data, 0);
    chk(empty_vec == 4'hF && underflow == 0, "R10 empty", empty_vec, 4'hF);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 5; i++) push(0, DW'(16'hA000 + i));
    push(1, 16'hB000); push(1, 16'hB001);
    fifo_addr = 0; cs_n = 0;
    oe_n = 0; wait_cyc(6);
    probe("R2 head shown", 16'hA000);
    wait_cyc(6);
    probe("R2 head not consumed", 16'hA000);
    // R3: unqualified strobe
    cs_n = 1; wait_cyc(3);
    rd_pulse(0);
    probe("R3 no consume without select", 16'hA000);
    cs_n = 0; wait_cyc(3);
    // R4: single pulse consumes once
    rd_pulse(0);
    probe("R4 one consume", 16'hA001);
    // R5: burst
    rd_pulse(0); probe("R5 burst N+1", 16'hA002);
    rd_pulse(0); probe("R5 burst N+2", 16'hA003);
    rd_pulse(0); probe("R5 burst N+3", 16'hA004);
    // R1: release
    oe_n = 1; wait_cyc(5);
    @(posedge clk); #3;
    chk(!bus_oe && bus_data == 0, "R1 released", bus_data, 0);
    @(negedge clk);
    // R11: address switch
    fifo_addr = 1; oe_n = 0; wait_cyc(6);
    probe("R11 queue 1 head", 16'hB000);
    fifo_addr = 0; wait_cyc(6);
    probe("R11 queue 0 head kept", 16'hA004);
    fifo_addr = 1; oe_n = 1; wait_cyc(6);
    // R6: tied strobes
    @(negedge clk); rd_n = 0; oe_n = 0; wait_cyc(5);
    probe("R6 tied shows head", 16'hB000);
    rd_n = 1; oe_n = 1; wait_cyc(5);
    oe_n = 0; wait_cyc(6);
    probe("R6 tied consumed once", 16'hB001);
    oe_n = 1; wait_cyc(3);
    // R7: empty read
    fifo_addr = 2; wait_cyc(5);
    rd_pulse(0);
    @(posedge clk); #3;
    chk(underflow == 1 && sel_empty == 1, "R7 underflow set", underflow, 1);
    @(negedge clk);
    push(2, 16'hC000);
    oe_n = 0; wait_cyc(6);
    probe("R7 pointer unmoved", 16'hC000);
    oe_n = 1;
    // R9/R8: fill queue 3
    fifo_addr = 3; wait_cyc(3);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      wr_valid = 1; wr_sel = 3; wr_data = DW'(16'h3000 + i);
      @(negedge clk);
    end
    wr_data = 16'hDEAD; @(negedge clk);
    wr_valid = 0;
    @(posedge clk); #3;
    chk(sel_full == 1 && wr_ready == 0, "R9 full backpressure", wr_ready, 0);
    chk(full_vec == 4'b1000, "R8 full_vec", full_vec, 4'b1000);
    @(negedge clk);
    rd_pulse(0);
    @(posedge clk); #3;
    chk(sel_full == 0 && wr_ready == 1, "R9 ready after read", wr_ready, 1);
    @(negedge clk);
    oe_n = 0; wait_cyc(6);
    probe("R4 queue 3 second word", 16'h3001);
    oe_n = 1; cs_n = 1; wait_cyc(6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule